// File: doc/BRIEF.md
# Single-to-Double Widening Loader with Class Tag

This block takes a 32-bit single-precision bit pattern as it arrives from memory and turns it into the 64-bit double-precision pattern that a wider floating-point register file holds. Alongside the value it produces a class tag, which the rest of the datapath uses to pick its fast paths. The tag has a 2-bit main class and a 3-bit subclass that refines the special class. The conversion is exact. No rounding takes place, because every single-precision value has an exact double-precision form.

NaN payloads are carried over bit for bit rather than collapsed to one value. The one "indefinite" pattern 0xFFC00000 is detected and replaced by a fixed native encoding. A parameter selects the NaN convention of the target. With the standard convention, a set top fraction bit means quiet. With the inverted convention, a set top fraction bit means signalling. The block registers its result once. The result appears one clock after a load is presented and holds until the next load.

Top module: `sp2dp_load_conv`

## Requirements
- R1: While rst_ni is low, valid_o, data_o, cls_o and sub_o are all zero.
- R2: A load presented with valid_i high appears on the outputs after exactly one rising clock edge, with valid_o high. While valid_i is low, valid_o is low at the next edge and data_o, cls_o and sub_o keep their previous values.
- R3: Tag encoding: cls_o is 0 for valid, 1 for zero and 2 for special. sub_o is 0 whenever cls_o is not special. For a normal input (exponent 1..254), data_o has the same sign, exponent plus 896 and the 23 fraction bits at data_o[51:29], and the tag is valid.
- R4: A zero input of either sign gives data_o equal to the sign in bit 63 and all other bits zero, with cls_o = 1.
- R5: A denormal input (exponent 0, fraction nonzero) is normalised. Let z be the number of leading zeros of the 23-bit fraction. The exponent becomes 896 − z, the fraction is shifted left by z+1 and placed at data_o[51:29], the sign is kept, and the tag is valid.
- R6: 0x7F800000 gives 0x7FF0000000000000 and 0xFF800000 gives 0xFFF0000000000000. Both are tagged cls_o = 2 with sub_o = 1 (infinity).
- R7: Input 0xFFC00000 is tagged cls_o = 2 with sub_o = 4 (indefinite). The output is 0xFFF8000000000000 with the standard convention (INV_NAN_POL = 0) and 0x7FF7FFFFFFFFFFFF with the inverted convention (INV_NAN_POL = 1).
- R8: Any other input with exponent 255 and a nonzero fraction is tagged cls_o = 2. sub_o is 2 (quiet) when input bit 22 is set and 3 (signalling) when it is clear. The choice depends only on the input bit and not on INV_NAN_POL.
- R9: Such a NaN widens to the input sign, exponent 0x7FF and the 23 fraction bits at data_o[51:29], with data_o[28:0] zero. Under INV_NAN_POL = 1, bit 22 of the fraction is inverted before it is placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A load pattern is present on data_i |
| data_i | input | 32 | Single-precision bit pattern |
| valid_o | output | 1 | Result registered from a load in the previous cycle |
| data_o | output | 64 | Double-precision bit pattern |
| cls_o | output | 2 | Main class: 0 valid, 1 zero, 2 special |
| sub_o | output | 3 | Subclass: 1 infinity, 2 quiet NaN, 3 signalling NaN, 4 indefinite, 5 denormal |

## Verification
The hardest behaviour to reach is the interaction between the polarity parameter and NaN classification. The tag must follow the input bit 22, while the widened payload carries that bit inverted. A single instance can never show both effects at once. The bench therefore runs a second instance built with the inverted convention next to the default one and feeds both the same quiet, signalling and indefinite patterns. Denormal normalisation is reached through the extreme fraction values: the single lowest bit, the full fraction, and a fraction with only the top bit set, which makes the shifted fraction all zeros.

// File: rtl/sp2dp_pkg.sv
package sp2dp_pkg;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_W      = 64;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_BIAS   = 127;
  localparam int DP_BIAS   = 1023;
  localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;

  typedef enum logic [1:0] {
    CLS_VALID   = 2'd0,
    CLS_ZERO    = 2'd1,
    CLS_SPECIAL = 2'd2
  } cls_e;

  typedef enum logic [2:0] {
    SUB_NONE   = 3'd0,
    SUB_INF    = 3'd1,
    SUB_QNAN   = 3'd2,
    SUB_SNAN   = 3'd3,
    SUB_INDEF  = 3'd4,
    SUB_DENORM = 3'd5
  } sub_e;

  typedef enum logic [2:0] {
    K_ZERO   = 3'd0,
    K_DENORM = 3'd1,
    K_NORMAL = 3'd2,
    K_INF    = 3'd3,
    K_NAN    = 3'd4,
    K_INDEF  = 3'd5
  } kind_e;

  typedef struct packed {
    cls_e cls;
    sub_e sub;
  } tag_t;
endpackage

// File: rtl/sp2dp_classify.sv
module sp2dp_classify
  import sp2dp_pkg::*;
(
  input  logic [SP_W-1:0] sp_i,
  output kind_e           kind_o,
  output logic            quiet_o
);
  localparam logic [SP_W-1:0] INDEF_PAT = 32'hFFC0_0000;

  logic [SP_EXP_W-1:0]  exp_f;
  logic [SP_FRAC_W-1:0] frac_f;
  logic exp_ones, exp_zero, frac_zero;

  assign exp_f     = sp_i[SP_W-2 -: SP_EXP_W];
  assign frac_f    = sp_i[SP_FRAC_W-1:0];
  assign exp_ones  = &exp_f;
  assign exp_zero  = ~|exp_f;
  assign frac_zero = ~|frac_f;
  // quiet decision taken on the raw input, before any polarity change
  assign quiet_o   = frac_f[SP_FRAC_W-1];

  always_comb begin
    if (exp_ones) begin
      if (frac_zero)              kind_o = K_INF;
      else if (sp_i == INDEF_PAT) kind_o = K_INDEF;
      else                        kind_o = K_NAN;
    end else if (exp_zero) begin
      kind_o = frac_zero ? K_ZERO : K_DENORM;
    end else begin
      kind_o = K_NORMAL;
    end
  end
endmodule

// File: rtl/sp2dp_lzc.sv
module sp2dp_lzc #(
  parameter int W  = 23,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  in_i,
  output logic [CW-1:0] cnt_o
);
  // highest set bit wins; all-zero input yields W
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (in_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/sp2dp_widen.sv
module sp2dp_widen
  import sp2dp_pkg::*;
#(
  parameter bit INV_NAN_POL = 1'b0
) (
  input  logic [SP_W-1:0] sp_i,
  input  kind_e           kind_i,
  output logic [DP_W-1:0] dp_o
);
  localparam int CW = $clog2(SP_FRAC_W + 1);
  localparam logic [DP_EXP_W-1:0] REBIAS  = DP_EXP_W'(DP_BIAS - SP_BIAS);
  localparam logic [DP_EXP_W-1:0] EXP_MAX = '1;

  logic                 sgn;
  logic [SP_EXP_W-1:0]  exp_f;
  logic [SP_FRAC_W-1:0] frac_f;
  logic [CW-1:0]        lz;
  logic [CW:0]          lz1;
  logic [SP_FRAC_W-1:0] dn_frac;
  logic [DP_EXP_W-1:0]  nm_exp, dn_exp;
  logic [SP_FRAC_W-1:0] qflip;
  logic [DP_W-1:0]      indef_pat;
  logic [SP_FRAC_W-1:0] nan_frac;

  assign sgn    = sp_i[SP_W-1];
  assign exp_f  = sp_i[SP_W-2 -: SP_EXP_W];
  assign frac_f = sp_i[SP_FRAC_W-1:0];

  sp2dp_lzc #(.W(SP_FRAC_W), .CW(CW)) u_lzc (
    .in_i  (frac_f),
    .cnt_o (lz)
  );

  // drop the leading one: shift by lz+1
  assign lz1     = {1'b0, lz} + 1'b1;
  assign dn_frac = frac_f << lz1;
  assign dn_exp  = REBIAS - DP_EXP_W'(lz);
  assign nm_exp  = DP_EXP_W'(exp_f) + REBIAS;

  generate
    if (INV_NAN_POL) begin : g_inv
      assign qflip     = {1'b1, {(SP_FRAC_W-1){1'b0}}};
      assign indef_pat = {1'b0, EXP_MAX, 1'b0, {(DP_FRAC_W-1){1'b1}}};
    end else begin : g_std
      assign qflip     = '0;
      assign indef_pat = {1'b1, EXP_MAX, 1'b1, {(DP_FRAC_W-1){1'b0}}};
    end
  endgenerate

  assign nan_frac = frac_f ^ qflip;

  always_comb begin
    unique case (kind_i)
      K_ZERO:   dp_o = {sgn, {(DP_W-1){1'b0}}};
      K_DENORM: dp_o = {sgn, dn_exp, dn_frac, {PAD_W{1'b0}}};
      K_NORMAL: dp_o = {sgn, nm_exp, frac_f, {PAD_W{1'b0}}};
      K_INF:    dp_o = {sgn, EXP_MAX, {DP_FRAC_W{1'b0}}};
      K_NAN:    dp_o = {sgn, EXP_MAX, nan_frac, {PAD_W{1'b0}}};
      K_INDEF:  dp_o = indef_pat;
      default:  dp_o = '0;
    endcase
  end
endmodule

// File: rtl/sp2dp_tagger.sv
module sp2dp_tagger
  import sp2dp_pkg::*;
(
  input  logic [DP_W-2:0] mag_i,
  input  kind_e           kind_i,
  input  logic            quiet_i,
  output tag_t            tag_o
);
  logic [DP_EXP_W-1:0]  dexp;
  logic [DP_FRAC_W-1:0] dfrac;

  assign dexp  = mag_i[DP_W-2 -: DP_EXP_W];
  assign dfrac = mag_i[DP_FRAC_W-1:0];

  always_comb begin
    tag_o = '{cls: CLS_VALID, sub: SUB_NONE};
    unique case (kind_i)
      K_INF:   tag_o = '{cls: CLS_SPECIAL, sub: SUB_INF};
      K_INDEF: tag_o = '{cls: CLS_SPECIAL, sub: SUB_INDEF};
      K_NAN:   tag_o = '{cls: CLS_SPECIAL, sub: (quiet_i ? SUB_QNAN : SUB_SNAN)};
      default: begin
        // finite: classify the widened result
        if (~|dexp && ~|dfrac) tag_o = '{cls: CLS_ZERO, sub: SUB_NONE};
        else if (~|dexp)       tag_o = '{cls: CLS_SPECIAL, sub: SUB_DENORM};
        else                   tag_o = '{cls: CLS_VALID, sub: SUB_NONE};
      end
    endcase
  end
endmodule

// File: rtl/sp2dp_load_conv.sv
module sp2dp_load_conv
  import sp2dp_pkg::*;
#(
  parameter bit INV_NAN_POL = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [SP_W-1:0] data_i,
  output logic            valid_o,
  output logic [DP_W-1:0] data_o,
  output logic [1:0]      cls_o,
  output logic [2:0]      sub_o
);
  kind_e           kind;
  logic            quiet;
  logic [DP_W-1:0] dp;
  tag_t            tag;

  sp2dp_classify u_cls (
    .sp_i    (data_i),
    .kind_o  (kind),
    .quiet_o (quiet)
  );

  sp2dp_widen #(.INV_NAN_POL(INV_NAN_POL)) u_wid (
    .sp_i   (data_i),
    .kind_i (kind),
    .dp_o   (dp)
  );

  sp2dp_tagger u_tag (
    .mag_i   (dp[DP_W-2:0]),
    .kind_i  (kind),
    .quiet_i (quiet),
    .tag_o   (tag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      cls_o   <= '0;
      sub_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= dp;
        cls_o  <= tag.cls;
        sub_o  <= tag.sub;
      end
    end
  end
endmodule

// File: rtl/sp2dp_load_conv_chk.sv
module sp2dp_load_conv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] data_i,
  input logic        valid_o,
  input logic [63:0] data_o,
  input logic [1:0]  cls_o,
  input logic [2:0]  sub_o
);
  logic in_nan;
  assign in_nan = (&data_i[30:23]) && (|data_i[22:0]) && (data_i != 32'hFFC0_0000);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_rst_idle_R1: assert (!valid_o && data_o == '0 && cls_o == '0 && sub_o == '0);
    end
  end

  assert_valid_pipe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(data_o) && $stable(cls_o) && $stable(sub_o)));

  assert_sub_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cls_o != 2'd2) |-> sub_o == 3'd0);

  assert_zero_mag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cls_o == 2'd1) |-> data_o[62:0] == '0);

  assert_special_exp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && data_o[62:52] == 11'h7FF) |-> cls_o == 2'd2);

  assert_nan_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_nan) |=> sub_o == ($past(data_i[22]) ? 3'd2 : 3'd3));

  assert_nan_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cls_o == 2'd2 && (sub_o == 3'd2 || sub_o == 3'd3))
      |-> (data_o[62:52] == 11'h7FF && data_o[28:0] == '0));
endmodule

bind sp2dp_load_conv sp2dp_load_conv_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .data_i  (data_i),
  .valid_o (valid_o),
  .data_o  (data_o),
  .cls_o   (cls_o),
  .sub_o   (sub_o)
);

// File: tb/sp2dp_load_conv_tb.sv
module sp2dp_load_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  localparam logic [31:0] VI [NV] = '{
    32'h3F80_0000, 32'hC049_0FDB, 32'h7F7F_FFFF, 32'h0080_0000,
    32'h0000_0000, 32'h8000_0000,
    32'h0000_0001, 32'h007F_FFFF, 32'h8040_0000, 32'h0000_0003,
    32'h7F80_0000, 32'hFF80_0000, 32'hFFC0_0000,
    32'h7FC0_0001, 32'h7F80_0001, 32'hFFBF_FFFF, 32'h7FFF_FFFF};
  localparam logic [63:0] VD [NV] = '{
    64'h3FF0_0000_0000_0000, 64'hC009_21FB_6000_0000, 64'h47EF_FFFF_E000_0000, 64'h3810_0000_0000_0000,
    64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'h36A0_0000_0000_0000, 64'h380F_FFFF_C000_0000, 64'hB800_0000_0000_0000, 64'h36B8_0000_0000_0000,
    64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 64'hFFF8_0000_0000_0000,
    64'h7FF8_0000_2000_0000, 64'h7FF0_0000_2000_0000, 64'hFFF7_FFFF_E000_0000, 64'h7FFF_FFFF_E000_0000};
  localparam logic [1:0] VC [NV] = '{
    2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0,
    2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2};
  localparam logic [2:0] VS [NV] = '{
    3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0,
    3'd1, 3'd1, 3'd4, 3'd2, 3'd3, 3'd3, 3'd2};
  localparam logic [15:0] VR [NV] = '{
    "R3", "R3", "R3", "R3", "R4", "R4", "R5", "R5", "R5", "R5",
    "R6", "R6", "R7", "R8", "R8", "R9", "R9"};

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [31:0] data_i;
  logic        valid_o, valid_o_inv;
  logic [63:0] data_o, data_o_inv;
  logic [1:0]  cls_o, cls_o_inv;
  logic [2:0]  sub_o, sub_o_inv;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp2dp_load_conv u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o), .cls_o(cls_o), .sub_o(sub_o));

  sp2dp_load_conv #(.INV_NAN_POL(1'b1)) u_dut_inv (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o_inv), .data_o(data_o_inv), .cls_o(cls_o_inv), .sub_o(sub_o_inv));

  // packed as {valid, cls, sub, data}
  task automatic chk(input logic [15:0] req, input logic [69:0] got, input logic [69:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] d);
    valid_i = v;
    data_i  = d;
    @(negedge clk);
  endtask

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    data_i  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {valid_o, cls_o, sub_o, data_o}, '0);
    chk("R1", {valid_o_inv, cls_o_inv, sub_o_inv, data_o_inv}, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VI[i]);
      chk(VR[i], {valid_o, cls_o, sub_o, data_o}, {1'b1, VC[i], VS[i], VD[i]});
    end

    // R2: hold with valid low, new data ignored
    drive(1'b1, 32'h3F80_0000);
    chk("R2", {valid_o, cls_o, sub_o, data_o}, {1'b1, 2'd0, 3'd0, 64'h3FF0_0000_0000_0000});
    drive(1'b0, 32'h7FC0_0001);
    chk("R2", {valid_o, cls_o, sub_o, data_o}, {1'b0, 2'd0, 3'd0, 64'h3FF0_0000_0000_0000});
    drive(1'b0, 32'h0000_0001);
    chk("R2", {valid_o, cls_o, sub_o, data_o}, {1'b0, 2'd0, 3'd0, 64'h3FF0_0000_0000_0000});

    // inverted polarity instance
    drive(1'b1, 32'hFFC0_0000);
    chk("R7", {valid_o_inv, cls_o_inv, sub_o_inv, data_o_inv}, {1'b1, 2'd2, 3'd4, 64'h7FF7_FFFF_FFFF_FFFF});
    drive(1'b1, 32'h7FC0_0001);
    chk("R8", {valid_o_inv, cls_o_inv, sub_o_inv, data_o_inv}, {1'b1, 2'd2, 3'd2, 64'h7FF0_0000_2000_0000});
    drive(1'b1, 32'h7F80_0001);
    chk("R9", {valid_o_inv, cls_o_inv, sub_o_inv, data_o_inv}, {1'b1, 2'd2, 3'd3, 64'h7FF8_0000_2000_0000});
    drive(1'b1, 32'hFFBF_FFFF);
    chk("R9", {valid_o_inv, cls_o_inv, sub_o_inv, data_o_inv}, {1'b1, 2'd2, 3'd3, 64'hFFFF_FFFF_E000_0000});
    drive(1'b1, 32'h3F80_0000);
    chk("R3", {valid_o_inv, cls_o_inv, sub_o_inv, data_o_inv}, {1'b1, 2'd0, 3'd0, 64'h3FF0_0000_0000_0000});

    // R1: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    chk("R1", {valid_o, cls_o, sub_o, data_o}, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(1'b1, 32'h8000_0000);
    chk("R4", {valid_o, cls_o, sub_o, data_o}, {1'b1, 2'd1, 3'd0, 64'h8000_0000_0000_0000});
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule